// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the serial slave front end of a byte-wide memory that has no write latency. A host drives a serial clock, a data input, an active-low select and an active-low pause line. All four are brought into a faster system clock through a synchroniser. The engine decodes a one-byte command and collects a byte address. It then streams data in or out, moving to the next address after each byte. The data output comes with a separate drive-enable, so the pad can be tristated outside the block.

The storage is a synchronous register array inside the block, with `2**ADDR_W` bytes (8192 by default). Write-enable state and block protection live in a separate protection unit. For every data byte of a write, the engine shows that unit the target address and obeys its combinational verdict. The engine also pulses the unit on latch-set and latch-clear commands. It hands the unit a new status byte, returns the unit's status byte on a status read, and signals when a write-type command is closed by deselect.

The system clock must run at least four times faster than the serial clock. Each written byte is committed in the system clock cycle after its eighth bit is detected. A read address is fetched two system clock cycles after it is formed.

Top module: `spi_mem_engine`

## Requirements
- R1: The first byte after select goes low is the command. Code 0x06 raises `op_wren` and code 0x04 raises `op_wrdi`, each for exactly one system clock cycle, after the eighth bit of that byte.
- R2: Both serial clock idle levels work (clock idling low or idling high while deselected). The data input is sampled on rising serial clock edges, and every byte travels most significant bit first.
- R3: After command 0x03 (read) or 0x02 (write), two address bytes follow, high byte first. Only the low `ADDR_W` bits of this 16-bit value are used; the bits above are ignored.
- R4: During a write, each data byte is stored at the current address as soon as its eighth bit is sampled. The address then increments, wrapping from the top location (0x1FFF by default) to 0x0000, for any number of bytes.
- R5: During a read, bytes are returned from the start address with the same increment and wrap rule. The output bit changes after falling serial clock edges, and the data input is ignored in this phase.
- R6: `so_oe` is low while deselected, during the command, address and write-data phases, and after the status byte of a status read.
- R7: With the pause line low (taken low and high only while the serial clock is low), serial clock edges are ignored and `so_oe` is low. The transfer then continues at the same bit position.
- R8: Only one command is accepted per select period. Bytes that follow a completed non-data command, and all bytes after an unknown code, are ignored until select rises.
- R9: When `chk_ok` is low for the current write address, that location keeps its old value, but the address still advances to the next byte.
- R10: Command 0x05 returns `sr_rd_data` as one byte. Command 0x01 takes one following byte, presents it on `sr_wr_data` and raises `sr_wr_stb` for one cycle.
- R11: When select rises to end a write (0x02) or status write (0x01) command, `wr_end` pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| hold_n | input | 1 | Active-low pause |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Drive enable for `so` |
| chk_addr | output | ADDR_W | Address being written, for the protection unit |
| chk_ok | input | 1 | Protection verdict for `chk_addr` |
| op_wren | output | 1 | Latch-set command pulse |
| op_wrdi | output | 1 | Latch-clear command pulse |
| sr_rd_data | input | 8 | Status byte supplied by the protection unit |
| sr_wr_stb | output | 1 | New status byte strobe |
| sr_wr_data | output | 8 | New status byte |
| wr_end | output | 1 | Write-type command closed by deselect |

## Verification
Two things happen in the same system clock cycle: a write byte is committed and the protection verdict for that byte's address is taken. The address counter also steps in that cycle. The bench provokes this by streaming three bytes across a single protected location, whose neighbours on both sides are unprotected. Reading the locations back must show the first and third bytes stored and the middle location unchanged. That proves the verdict was taken for the right address and the counter still advanced. A second collision, a byte completing exactly at the top address, is judged by a write and read that cross the wrap point.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

   localparam logic [7:0] OPC_WREN  = 8'h06;
   localparam logic [7:0] OPC_WRDI  = 8'h04;
   localparam logic [7:0] OPC_RDSR  = 8'h05;
   localparam logic [7:0] OPC_WRSR  = 8'h01;
   localparam logic [7:0] OPC_READ  = 8'h03;
   localparam logic [7:0] OPC_WRITE = 8'h02;

   typedef enum logic [2:0] {
      PH_OPC,
      PH_ADH,
      PH_ADL,
      PH_WDAT,
      PH_RDAT,
      PH_SRD,
      PH_SWR,
      PH_IGN
   } phase_t;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
   parameter int              W       = 4,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_mem_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= RST_VAL;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= RST_VAL;
            else        st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] wa,
   input  logic [7:0]        wd,
   input  logic [ADDR_W-1:0] ra,
   output logic [7:0]        rq
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[wa] <= wd;
      rq <= mem[ra];
   end

endmodule

// File: rtl/spi_mem_frame.sv
module spi_mem_frame
   import spi_mem_pkg::*;
#(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              si_s,
   input  logic              cs_n_s,
   input  logic              hold_n_s,
   input  logic [7:0]        rd_q,
   input  logic [7:0]        sr_rd_data,
   input  logic              chk_ok,
   output logic [ADDR_W-1:0] addr,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_wa,
   output logic [7:0]        mem_wd,
   output logic              so_bit,
   output logic              oe_r,
   output logic              op_wren,
   output logic              op_wrdi,
   output logic              sr_wr_stb,
   output logic [7:0]        sr_wr_data,
   output logic              wr_end
);

   localparam int                HI_W = ADDR_W - 8;
   localparam logic [ADDR_W-1:0] ONE  = 1;

   phase_t          ph;
   logic [2:0]      bcnt;
   logic [6:0]      sh;
   logic [HI_W-1:0] ahi;
   logic            rd_op;
   logic            wr_op;
   logic            sck_q;
   logic [7:0]      osh;

   logic       active, rise, fall, last, out_ph;
   logic [7:0] inbyte, src;

   assign active = !cs_n_s && hold_n_s;
   assign rise   = active &&  sck_s && !sck_q;
   assign fall   = active && !sck_s &&  sck_q;
   assign inbyte = {sh, si_s};
   assign last   = (bcnt == 3'd7);
   assign out_ph = (ph == PH_RDAT) || (ph == PH_SRD);
   assign src    = (ph == PH_SRD) ? sr_rd_data : rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q      <= 1'b0;
         ph         <= PH_OPC;
         bcnt       <= '0;
         sh         <= '0;
         ahi        <= '0;
         rd_op      <= 1'b0;
         wr_op      <= 1'b0;
         addr       <= '0;
         mem_we     <= 1'b0;
         mem_wa     <= '0;
         mem_wd     <= '0;
         osh        <= '0;
         so_bit     <= 1'b0;
         oe_r       <= 1'b0;
         op_wren    <= 1'b0;
         op_wrdi    <= 1'b0;
         sr_wr_stb  <= 1'b0;
         sr_wr_data <= '0;
         wr_end     <= 1'b0;
      end else begin
         sck_q     <= sck_s;
         mem_we    <= 1'b0;
         op_wren   <= 1'b0;
         op_wrdi   <= 1'b0;
         sr_wr_stb <= 1'b0;
         wr_end    <= 1'b0;
         if (cs_n_s) begin
            ph     <= PH_OPC;
            bcnt   <= '0;
            oe_r   <= 1'b0;
            rd_op  <= 1'b0;
            wr_op  <= 1'b0;
            wr_end <= wr_op;
         end else if (rise) begin
            sh   <= inbyte[6:0];
            bcnt <= bcnt + 3'd1;
            if (last) begin
               case (ph)
                  PH_OPC: begin
                     case (inbyte)
                        OPC_WREN:  begin op_wren <= 1'b1; ph <= PH_IGN; end
                        OPC_WRDI:  begin op_wrdi <= 1'b1; ph <= PH_IGN; end
                        OPC_RDSR:  ph <= PH_SRD;
                        OPC_WRSR:  begin wr_op <= 1'b1; ph <= PH_SWR; end
                        OPC_READ:  begin rd_op <= 1'b1; ph <= PH_ADH; end
                        OPC_WRITE: begin wr_op <= 1'b1; ph <= PH_ADH; end
                        default:   ph <= PH_IGN;
                     endcase
                  end
                  PH_ADH: begin
                     ahi <= inbyte[HI_W-1:0];
                     ph  <= PH_ADL;
                  end
                  PH_ADL: begin
                     addr <= {ahi, inbyte};
                     ph   <= rd_op ? PH_RDAT : PH_WDAT;
                  end
                  PH_WDAT: begin
                     mem_we <= chk_ok;
                     mem_wa <= addr;
                     mem_wd <= inbyte;
                     addr   <= addr + ONE;
                  end
                  PH_RDAT: addr <= addr + ONE;
                  PH_SRD: begin
                     ph   <= PH_IGN;
                     oe_r <= 1'b0;
                  end
                  PH_SWR: begin
                     sr_wr_stb  <= 1'b1;
                     sr_wr_data <= inbyte;
                     ph         <= PH_IGN;
                  end
                  default: ;
               endcase
            end
         end else if (fall && out_ph) begin
            oe_r <= 1'b1;
            if (bcnt == 3'd0) begin
               so_bit <= src[7];
               osh    <= {src[6:0], 1'b0};
            end else begin
               so_bit <= osh[7];
               osh    <= {osh[6:0], 1'b0};
            end
         end
      end
   end

   // R4: every committed write byte moves the address on by exactly one
   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && last && ph == PH_WDAT) |=> (addr == $past(addr) + ONE));

   // R6: no drive outside the read-return phases
   assert_quiet_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_OPC || ph == PH_ADH || ph == PH_ADL || ph == PH_WDAT || ph == PH_SWR)
         |-> !oe_r);

   // R7: a paused, selected transfer keeps its bit position and phase
   assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_n_s && !cs_n_s) |=> ($stable(bcnt) && $stable(ph)));

   // R1, R10, R11: command side pulses never overlap
   assert_pulse_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_wren, op_wrdi, sr_wr_stb, wr_end}));

endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine #(
   parameter int ADDR_W      = 13,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              cs_n,
   input  logic              hold_n,
   input  logic              si,
   output logic              so,
   output logic              so_oe,
   output logic [ADDR_W-1:0] chk_addr,
   input  logic              chk_ok,
   output logic              op_wren,
   output logic              op_wrdi,
   input  logic [7:0]        sr_rd_data,
   output logic              sr_wr_stb,
   output logic [7:0]        sr_wr_data,
   output logic              wr_end
);

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
      $error("spi_mem_engine: ADDR_W must lie in 9..16");
   end

   logic [3:0]        pins_s;
   logic              sck_s, si_s, cs_n_s, hold_n_s;
   logic [7:0]        rd_q;
   logic [ADDR_W-1:0] addr, mem_wa;
   logic              mem_we, so_bit, oe_r;
   logic [7:0]        mem_wd;

   spi_mem_sync #(
      .W       (4),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (4'b1100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({hold_n, cs_n, si, sck}),
      .q     (pins_s)
   );

   assign {hold_n_s, cs_n_s, si_s, sck_s} = pins_s;

   spi_mem_frame #(.ADDR_W(ADDR_W)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_s      (sck_s),
      .si_s       (si_s),
      .cs_n_s     (cs_n_s),
      .hold_n_s   (hold_n_s),
      .rd_q       (rd_q),
      .sr_rd_data (sr_rd_data),
      .chk_ok     (chk_ok),
      .addr       (addr),
      .mem_we     (mem_we),
      .mem_wa     (mem_wa),
      .mem_wd     (mem_wd),
      .so_bit     (so_bit),
      .oe_r       (oe_r),
      .op_wren    (op_wren),
      .op_wrdi    (op_wrdi),
      .sr_wr_stb  (sr_wr_stb),
      .sr_wr_data (sr_wr_data),
      .wr_end     (wr_end)
   );

   spi_mem_array #(.ADDR_W(ADDR_W)) u_array (
      .clk (clk),
      .we  (mem_we),
      .wa  (mem_wa),
      .wd  (mem_wd),
      .ra  (addr),
      .rq  (rd_q)
   );

   assign chk_addr = addr;
   assign so       = so_bit;
   assign so_oe    = oe_r && hold_n_s && !cs_n_s;

   // R9: the array is only written after a favourable protection verdict
   assert_prot_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(chk_ok));

   // R7: no drive while paused
   assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_n_s |-> !so_oe);

endmodule

// File: tb/sim_spi_mem_engine.sv
module sim_spi_mem_engine;

   localparam int CLK_P = 10;
   localparam int HALF  = 8 * CLK_P;
   localparam int AW    = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
   logic          so, so_oe;
   logic [AW-1:0] chk_addr;
   logic          chk_ok;
   logic          op_wren, op_wrdi, sr_wr_stb, wr_end;
   logic [7:0]    sr_rd_data = 8'hA5;
   logic [7:0]    sr_wr_data;

   logic          prot_on = 1'b0;
   logic [AW-1:0] prot_addr = '0;
   logic          mode3 = 1'b0;

   int total = 0, bad = 0;
   int n_wren = 0, n_wrdi = 0, n_srw = 0, n_end = 0;
   logic [7:0] last_srw = 8'h00;
   logic oe_seen = 1'b0;

   assign chk_ok = !(prot_on && chk_addr == prot_addr);

   always #(CLK_P/2) clk = ~clk;

   spi_mem_engine #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
      .so(so), .so_oe(so_oe), .chk_addr(chk_addr), .chk_ok(chk_ok),
      .op_wren(op_wren), .op_wrdi(op_wrdi), .sr_rd_data(sr_rd_data),
      .sr_wr_stb(sr_wr_stb), .sr_wr_data(sr_wr_data), .wr_end(wr_end)
   );

   always @(posedge clk) begin
      if (op_wren)   n_wren <= n_wren + 1;
      if (op_wrdi)   n_wrdi <= n_wrdi + 1;
      if (sr_wr_stb) begin n_srw <= n_srw + 1; last_srw <= sr_wr_data; end
      if (wr_end)    n_end <= n_end + 1;
      if (so_oe)     oe_seen <= 1'b1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cs_open();
      sck = mode3;
      #(HALF);
      cs_n = 1'b0;
      #(HALF);
   endtask

   task automatic cs_close();
      if (!mode3) begin sck = 1'b0; #(HALF); end
      cs_n = 1'b1;
      #(2*HALF);
   endtask

   task automatic bit_io(input logic b, output logic r);
      sck = 1'b0; si = b;
      #(HALF);
      r = so;
      sck = 1'b1;
      #(HALF);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) bit_io(tx[i], rx[i]);
   endtask

   task automatic send(input logic [7:0] tx);
      logic [7:0] d;
      xfer(tx, d);
   endtask

   task automatic mem_write(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input int n);
      cs_open();
      send(8'h02); send(a[15:8]); send(a[7:0]);
      send(d0);
      if (n > 1) send(d1);
      if (n > 2) send(d2);
      cs_close();
   endtask

   task automatic mem_read3(input logic [15:0] a, output logic [7:0] r0, output logic [7:0] r1,
                            output logic [7:0] r2);
      cs_open();
      send(8'h03); send(a[15:8]); send(a[7:0]);
      xfer(8'hFF, r0); xfer(8'h5A, r1); xfer(8'h00, r2);
      cs_close();
   endtask

   task automatic t_reset();
      chk(so_oe == 1'b0, "R6 reset", so_oe, 0);
      chk(n_wren == 0 && n_wrdi == 0, "R1 reset pulses", n_wren + n_wrdi, 0);
   endtask

   task automatic t_latch_cmds();
      mode3 = 1'b0;
      cs_open(); send(8'h06); cs_close();
      chk(n_wren == 1, "R1 wren mode0", n_wren, 1);
      mode3 = 1'b1;
      cs_open(); send(8'h04); cs_close();
      chk(n_wrdi == 1, "R1 R2 wrdi mode3", n_wrdi, 1);
      mode3 = 1'b0;
   endtask

   task automatic t_write_read();
      logic [7:0] a, b, c;
      int e0;
      e0 = n_end;
      mode3 = 1'b0;
      mem_write(16'hE010, 8'h12, 8'h34, 8'h56, 3);
      chk(n_end == e0 + 1, "R11 wr_end after write", n_end, e0 + 1);
      mode3 = 1'b1;
      mem_read3(16'h0010, a, b, c);
      chk(a == 8'h12, "R3 R4 R5 byte0", a, 8'h12);
      chk(b == 8'h34 && c == 8'h56, "R2 R5 stream", {b, c}, 16'h3456);
      mode3 = 1'b0;
      chk(oe_seen == 1'b1, "R5 drive during read", oe_seen, 1);
   endtask

   task automatic t_wrap();
      logic [7:0] a, b, c;
      mem_write(16'h1FFE, 8'hAA, 8'hBB, 8'hCC, 3);
      mem_read3(16'h1FFE, a, b, c);
      chk(a == 8'hAA && b == 8'hBB, "R4 top bytes", {a, b}, 16'hAABB);
      chk(c == 8'hCC, "R4 R5 wrap to zero", c, 8'hCC);
   endtask

   task automatic t_protect();
      logic [7:0] a, b, c;
      mem_write(16'h17FF, 8'h50, 8'h51, 8'h52, 3);
      prot_on = 1'b1; prot_addr = 13'h1800;
      mem_write(16'h17FF, 8'h01, 8'h02, 8'h03, 3);
      prot_on = 1'b0;
      mem_read3(16'h17FF, a, b, c);
      chk(a == 8'h01, "R9 below protected", a, 8'h01);
      chk(b == 8'h51, "R9 protected kept", b, 8'h51);
      chk(c == 8'h03, "R9 address advanced", c, 8'h03);
   endtask

   task automatic t_status();
      logic [7:0] r;
      int e0;
      cs_open(); send(8'h05); xfer(8'h00, r);
      oe_seen = 1'b0;
      send(8'h00);
      cs_close();
      chk(r == 8'hA5, "R10 status read", r, 8'hA5);
      chk(oe_seen == 1'b0, "R6 quiet after status byte", oe_seen, 0);
      e0 = n_end;
      mode3 = 1'b1;
      cs_open(); send(8'h01); send(8'h8C); cs_close();
      mode3 = 1'b0;
      chk(n_srw == 1 && last_srw == 8'h8C, "R10 status write", last_srw, 8'h8C);
      chk(n_end == e0 + 1, "R11 wr_end after status write", n_end, e0 + 1);
   endtask

   task automatic t_ignore();
      logic [7:0] a, b, c;
      int w0;
      mem_write(16'h0020, 8'h33, 8'h00, 8'h00, 1);
      w0 = n_wren;
      cs_open(); send(8'h06); send(8'h02); send(8'h00); send(8'h20); send(8'h99); send(8'h06);
      cs_close();
      chk(n_wren == w0 + 1, "R8 one command per select", n_wren, w0 + 1);
      oe_seen = 1'b0;
      cs_open(); send(8'h77); send(8'h03); send(8'h00); send(8'h20); send(8'h00); cs_close();
      chk(oe_seen == 1'b0, "R8 unknown code silent", oe_seen, 0);
      mem_read3(16'h0020, a, b, c);
      chk(a == 8'h33, "R8 trailing bytes ignored", a, 8'h33);
   endtask

   task automatic t_hold();
      logic [7:0] r, a, b, c;
      logic x;
      mem_write(16'h0100, 8'hC3, 8'h00, 8'h00, 1);
      cs_open();
      send(8'h03); send(8'h01); send(8'h00);
      for (int i = 7; i >= 4; i--) bit_io(1'b0, r[i]);
      sck = 1'b0; #(HALF);
      hold_n = 1'b0; #(HALF);
      chk(so_oe == 1'b0, "R7 no drive while paused", so_oe, 0);
      for (int k = 0; k < 3; k++) begin sck = 1'b1; #(HALF); sck = 1'b0; #(HALF); end
      hold_n = 1'b1; #(HALF);
      for (int i = 3; i >= 0; i--) bit_io(1'b0, r[i]);
      cs_close();
      chk(r == 8'hC3, "R7 read resumes in place", r, 8'hC3);
      cs_open();
      send(8'h02); send(8'h01); send(8'h01);
      for (int i = 7; i >= 4; i--) bit_io(1'(8'h3C >> i), x);
      sck = 1'b0; #(HALF);
      hold_n = 1'b0; #(HALF);
      for (int k = 0; k < 3; k++) begin si = ~si; sck = 1'b1; #(HALF); sck = 1'b0; #(HALF); end
      hold_n = 1'b1; #(HALF);
      for (int i = 3; i >= 0; i--) bit_io(1'(8'h3C >> i), x);
      cs_close();
      mem_read3(16'h0101, a, b, c);
      chk(a == 8'h3C, "R7 write resumes in place", a, 8'h3C);
   endtask

   initial begin
      #(CLK_P * 150000);
      bad++; total++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_P * 5);
      rst_n = 1'b1;
      #(CLK_P * 5 + 2);
      t_reset();
      t_latch_cmds();
      t_write_read();
      t_wrap();
      t_protect();
      t_status();
      t_ignore();
      t_hold();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule